// File: doc/BRIEF.md
# Result FIFO with Temperature Slot

This block sits between a converter's result path and a serial read port. It keeps up to sixteen voltage results in a circular buffer, plus one separate temperature result. It hands the results out one bit at a time on a single data output. A host reads them in two-byte frames while a select line is held low. The serial clock is seen as a one-cycle falling-edge strobe `sclk_fall`, already brought into the block clock domain. The data output is registered, so it follows each event by one `clk` cycle.

Both kinds of result travel as a 16-bit frame: four zero bits first, then a 12-bit payload, most significant bit first. For a voltage the payload is the 10-bit result followed by two sub-bits. For a temperature it is a two's-complement value in eighths of a degree. A waiting temperature frame always goes out before any voltage frame. Hosts that drop the select line partway through a frame are handled by fixed rules, so that later frames still line up on byte boundaries.

Top module: `result_fifo_tslot`

## Requirements
- R1: The block stores up to 16 voltage results at once, plus one temperature result, and returns them in push order.
- R2: A voltage push while 16 results are stored, with no frame completing in that cycle, discards the oldest stored result. The 16 most recent results remain.
- R3: A voltage frame is 4 zero bits, then `vres` MSB first, then `vsub` MSB first: 16 bits in all.
- R4: A temperature frame is 4 zero bits, then the 12-bit two's-complement `tval`, MSB first.
- R5: A stored temperature result is sent before any voltage frame. A second temperature push before the first is read replaces it.
- R6: While `cs_n` is low, each `sclk_fall` pulse advances the frame by one bit. `sclk_fall` has no effect while `cs_n` is high. After the select line falls, `dout` shows the first bit still to be sent, and `dout` is 0 while nothing is stored.
- R7: If `cs_n` rises after k bits of a frame, with 1 <= k <= 7, the next 8 bits read are bits k to k+7 of that frame. The rest of that frame is then dropped.
- R8: If `cs_n` rises after exactly 8 bits, the next 8 bits read finish that frame. If it rises after 9 to 15 bits, the rest of that frame is dropped and the next read starts with the following frame.
- R9: A `clr` pulse empties the buffer and the temperature slot and restarts the bit position, so the frame pushed next is read from its first bit.
- R10: A result leaves storage only when its last bit is sent or when R7/R8 drop it. A voltage push in the same cycle as a frame completes is kept, and nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | One-cycle pulse that empties all storage |
| vpush | input | 1 | Voltage result valid, one cycle per result |
| vres | input | RES_W | Voltage conversion result |
| vsub | input | SUB_W | Sub-bits sent after the result |
| tpush | input | 1 | Temperature result valid |
| tval | input | RES_W+SUB_W | Temperature, two's complement, 1/8 degree per LSB |
| cs_n | input | 1 | Active-low read select |
| sclk_fall | input | 1 | One-cycle strobe for each falling serial clock edge |
| dout | output | 1 | Serial data, registered |

## Verification
The checker watches a set of properties on every cycle. Clearing leaves everything empty. An empty block drives a low output, and the four leading zeros of every frame come out low. The bit position does not move while the select line is high. An overwrite keeps the buffer full, and a lone push raises the occupancy by one. Only the bench scenarios can show that payload bits come out in the right order, and that a temperature frame goes first and replaces an unread one. They also show where each partial-read rule resumes at every interruption point from 1 to 15 bits, which entries survive an overflow, and that a push landing on the completing bit of a full buffer loses nothing.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  // Which store supplies the frame being shifted out.
  typedef enum logic {
    SRC_VOLT = 1'b0,
    SRC_TEMP = 1'b1
  } rd_src_e;
endpackage

// File: rtl/rfifo_vbuf.sv
module rfifo_vbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         nonempty
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int VCW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok, ovw;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == VCW'(DEPTH));
  assign nonempty = (count != '0);
  assign pop_ok   = pop & nonempty;
  assign ovw      = push & full & ~pop_ok;
  assign rdata    = mem[rd_ptr];

  // storage has no reset so it maps onto memory cells
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop_ok || ovw) rd_ptr <= nxt(rd_ptr);
      if (push && !pop_ok && !full) count <= count + 1'b1;
      else if (!push && pop_ok)     count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rfifo_tslot.sv
module rfifo_tslot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= wdata;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rfifo_rdctl.sv
module rfifo_rdctl #(
  parameter int ENTRY_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         cs_n,
  input  logic                         sclk_fall,
  input  logic                         head_valid,
  output logic [$clog2(ENTRY_W+1)-1:0] cnt,
  output logic                         busy,
  output logic                         pop
);
  localparam int CW = $clog2(ENTRY_W+1);
  localparam int SW = $clog2(BYTE_W);

  logic          cs_q, trunc;
  logic [SW-1:0] tstart;
  logic          cs_rise, shift, done_shift, discard, start_tr;
  logic [CW-1:0] end_pos;

  assign cs_rise    = cs_n & ~cs_q;
  assign shift      = sclk_fall & ~cs_n & head_valid;
  assign end_pos    = trunc ? (CW'(tstart) + CW'(BYTE_W)) : CW'(ENTRY_W);
  assign done_shift = shift && ((cnt + CW'(1)) == end_pos);
  // an interrupted truncated byte, or a second byte cut short, drops the frame
  assign discard    = cs_rise && head_valid &&
                      (trunc ? (cnt != CW'(tstart)) : (cnt > CW'(BYTE_W)));
  assign start_tr   = cs_rise && head_valid && !trunc &&
                      (cnt != '0) && (cnt < CW'(BYTE_W));
  assign pop        = done_shift | discard;
  assign busy       = (cnt != '0) | trunc;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      trunc  <= 1'b0;
      tstart <= '0;
    end else if (pop) begin
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (shift) begin
      cnt <= cnt + CW'(1);
    end else if (start_tr) begin
      trunc  <= 1'b1;
      tstart <= cnt[SW-1:0];
    end
  end
endmodule

// File: rtl/result_fifo_tslot.sv
module result_fifo_tslot
  import rfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RES_W  = 10,
  parameter int SUB_W  = 2,
  parameter int LEAD_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   vpush,
  input  logic [RES_W-1:0]       vres,
  input  logic [SUB_W-1:0]       vsub,
  input  logic                   tpush,
  input  logic [RES_W+SUB_W-1:0] tval,
  input  logic                   cs_n,
  input  logic                   sclk_fall,
  output logic                   dout
);
  localparam int PAY_W   = RES_W + SUB_W;
  localparam int ENTRY_W = LEAD_W + PAY_W;
  localparam int CW      = $clog2(ENTRY_W+1);
  localparam int IW      = $clog2(ENTRY_W);
  localparam int VCW     = $clog2(DEPTH+1);

  logic [PAY_W-1:0]   v_data, t_data, payload;
  logic [VCW-1:0]     v_count;
  logic               v_full, v_nonempty, t_valid;
  logic [CW-1:0]      cnt;
  logic               busy, pop, pop_v, pop_t, head_valid;
  rd_src_e            src_q, head_src;
  logic [ENTRY_W-1:0] frame;
  logic [IW-1:0]      idx;

  rfifo_vbuf #(.DEPTH(DEPTH), .W(PAY_W)) u_vbuf (
    .clk(clk), .rst(rst), .clr(clr), .push(vpush), .wdata({vres, vsub}),
    .pop(pop_v), .rdata(v_data), .count(v_count), .full(v_full),
    .nonempty(v_nonempty));

  rfifo_tslot #(.W(PAY_W)) u_tslot (
    .clk(clk), .rst(rst), .clr(clr), .push(tpush), .wdata(tval),
    .pop(pop_t), .valid(t_valid), .data(t_data));

  rfifo_rdctl #(.ENTRY_W(ENTRY_W), .BYTE_W(BYTE_W)) u_rdctl (
    .clk(clk), .rst(rst), .clr(clr), .cs_n(cs_n), .sclk_fall(sclk_fall),
    .head_valid(head_valid), .cnt(cnt), .busy(busy), .pop(pop));

  // source is chosen at a frame boundary and held until the frame ends
  assign head_src   = busy ? src_q : (t_valid ? SRC_TEMP : SRC_VOLT);
  assign head_valid = (head_src == SRC_TEMP) ? t_valid : v_nonempty;
  assign pop_t      = pop & (head_src == SRC_TEMP);
  assign pop_v      = pop & (head_src == SRC_VOLT);
  assign payload    = (head_src == SRC_TEMP) ? t_data : v_data;
  assign frame      = {{LEAD_W{1'b0}}, payload};
  assign idx        = IW'(ENTRY_W-1) - cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      src_q <= SRC_VOLT;
      dout  <= 1'b0;
    end else begin
      src_q <= head_src;
      dout  <= head_valid & frame[idx];
    end
  end
endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk #(
  parameter int DEPTH  = 16,
  parameter int LEAD_W = 4,
  parameter int CW     = 5,
  parameter int VCW    = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           clr,
  input logic           cs_n,
  input logic           vpush,
  input logic           dout,
  input logic [CW-1:0]  cnt,
  input logic [VCW-1:0] v_count,
  input logic           v_full,
  input logic           pop_v,
  input logic           head_valid,
  input logic           t_valid
);
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (v_count == '0 && !t_valid && cnt == '0));

  a_r6_empty_low: assert property (@(posedge clk) disable iff (rst)
    !head_valid |=> !dout);

  a_r3_lead_zeros: assert property (@(posedge clk) disable iff (rst)
    (head_valid && cnt < CW'(LEAD_W)) |=> !dout);

  a_r6_cs_high_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && !clr) |=> $stable(cnt));

  a_r2_full_stays: assert property (@(posedge clk) disable iff (rst)
    (v_full && vpush && !pop_v && !clr) |=> v_full);

  a_r10_push_count: assert property (@(posedge clk) disable iff (rst)
    (vpush && !pop_v && !v_full && !clr) |=> v_count == $past(v_count) + VCW'(1));

  a_r1_bounded: assert property (@(posedge clk) disable iff (rst)
    v_count <= VCW'(DEPTH));
endmodule

bind result_fifo_tslot rfifo_chk #(
  .DEPTH(DEPTH), .LEAD_W(LEAD_W), .CW(CW), .VCW(VCW)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .cs_n(cs_n), .vpush(vpush), .dout(dout),
  .cnt(cnt), .v_count(v_count), .v_full(v_full), .pop_v(pop_v),
  .head_valid(head_valid), .t_valid(t_valid));

// File: tb/result_fifo_tslot_bench.sv
`timescale 1ns/1ps
module result_fifo_tslot_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, vpush = 1'b0, tpush = 1'b0;
  logic cs_n = 1'b1, sclk_fall = 1'b0;
  logic [9:0]  vres = '0;
  logic [1:0]  vsub = '0;
  logic [11:0] tval = '0;
  logic dout;
  int checks = 0, errors = 0;
  int vq[$];
  bit tpend = 0;
  int tmodel = 0;

  always #2.5 clk = ~clk;

  result_fifo_tslot u_result_fifo_tslot (
    .clk(clk), .rst(rst), .clr(clr), .vpush(vpush), .vres(vres), .vsub(vsub),
    .tpush(tpush), .tval(tval), .cs_n(cs_n), .sclk_fall(sclk_fall), .dout(dout));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic push_volt(input int r, input int s);
    @(negedge clk); vpush = 1'b1; vres = 10'(r); vsub = 2'(s);
    @(negedge clk); vpush = 1'b0;
    if (vq.size() == 16) void'(vq.pop_front());
    vq.push_back(((r & 10'h3FF) << 2) | (s & 3));
  endtask

  task automatic push_temp(input int t);
    @(negedge clk); tpush = 1'b1; tval = 12'(t);
    @(negedge clk); tpush = 1'b0;
    tpend = 1; tmodel = t & 12'hFFF;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    vq.delete(); tpend = 0;
  endtask

  task automatic cs_set(input logic v);
    @(negedge clk); cs_n = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulse(input bit with_push, input int r, input int s);
    @(negedge clk); sclk_fall = 1'b1;
    if (with_push) begin vpush = 1'b1; vres = 10'(r); vsub = 2'(s); end
    @(negedge clk); sclk_fall = 1'b0; vpush = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_bits(input int n, output int w);
    w = 0;
    for (int i = 0; i < n; i++) begin
      w = (w << 1) | int'(dout);
      pulse(0, 0, 0);
    end
  endtask

  function automatic int model_next();
    if (tpend) begin tpend = 0; return tmodel; end
    if (vq.size() != 0) return vq.pop_front();
    return 0;
  endfunction

  task automatic read_expect(input string req);
    int w;
    read_bits(16, w);
    check(req, w, model_next());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w, x, y;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 reset dout", int'(dout), 0);
    cs_set(1'b0);
    read_bits(16, w);
    check("R6 empty reads zero", w, 0);
    cs_set(1'b1);

    // R1 R3 basic ordering
    for (int i = 0; i < 5; i++) push_volt(i * 211 + 17, i);
    cs_set(1'b0);
    for (int i = 0; i < 5; i++) read_expect("R3 voltage frame");
    read_expect("R6 empty after drain");
    cs_set(1'b1);

    // R2 overflow keeps newest 16
    for (int i = 0; i < 19; i++) push_volt(i * 41 + 3, i & 3);
    check("R1 model depth", vq.size(), 16);
    cs_set(1'b0);
    for (int i = 0; i < 17; i++) read_expect("R2 overwrite order");
    cs_set(1'b1);

    // R4 R5 temperature first, newest wins
    push_volt(10'h155, 1);
    push_temp(12'h0C8);
    push_volt(10'h2AA, 2);
    push_temp(12'hF38);
    cs_set(1'b0);
    for (int i = 0; i < 4; i++) read_expect("R5 temperature priority");
    cs_set(1'b1);

    // R6 clocks while deselected are ignored
    push_volt(10'h3C3, 3);
    for (int i = 0; i < 5; i++) pulse(0, 0, 0);
    cs_set(1'b0);
    read_expect("R6 sclk ignored while deselected");
    cs_set(1'b1);

    // R7 R8 sweep of every interruption point
    for (int k = 1; k < 16; k++) begin
      do_clear();
      push_volt((k * 37 + 5) & 10'h3FF, k & 3);
      push_volt((k * 53 + 900) & 10'h3FF, (k + 1) & 3);
      x = model_next();
      y = model_next();
      cs_set(1'b0);
      read_bits(k, w);
      check("R7 partial prefix", w, (x >> (16 - k)) & ((1 << k) - 1));
      cs_set(1'b1);
      cs_set(1'b0);
      if (k < 8) begin
        read_bits(8, w);
        check("R7 resumed byte", w, (x >> (8 - k)) & 8'hFF);
      end else if (k == 8) begin
        read_bits(8, w);
        check("R8 second byte resumes", w, x & 8'hFF);
      end
      read_bits(16, w);
      check(k > 8 ? "R8 remainder dropped" : "R7 next frame intact", w, y);
      read_bits(16, w);
      check("R7 empty after", w, 0);
      cs_set(1'b1);
    end

    // R9 clear drops everything, including mid-frame
    push_volt(10'h111, 1);
    push_temp(12'h123);
    do_clear();
    cs_set(1'b0);
    read_expect("R9 cleared reads zero");
    push_volt(10'h0F0, 2);
    read_bits(5, w);
    do_clear();
    push_volt(10'h30C, 1);
    read_expect("R9 frame after clear from bit 0");
    cs_set(1'b1);

    // R10 push on the completing bit of a full buffer loses nothing
    for (int i = 0; i < 16; i++) push_volt(i * 59 + 11, i & 3);
    cs_set(1'b0);
    read_bits(15, w);
    pulse(1, 10'h2E7, 3);
    check("R10 first frame bits", w, vq[0] >> 1);
    void'(vq.pop_front());
    vq.push_back((10'h2E7 << 2) | 3);
    for (int i = 0; i < 17; i++) read_expect("R10 push during pop");
    cs_set(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule